// File: doc/BRIEF.md
# Recently Opened Row Holding Cache

This block keeps a small, fully associative set of row numbers that were recently opened in a DRAM bank. The memory controller probes it only after a request has missed in the currently open row buffer. A hit means the row's contents can be returned from the nearby holding store, which is faster than precharging and activating the bank. A miss means the full DRAM path is taken. The row is then installed here, and if no slot is free it displaces an older one.

The eviction order is chosen per lookup by a configuration input. In first-in-first-out order, the slot that was installed longest ago goes first, and hits do not change that order. In least-recently-used order, a hit refreshes the slot. An invalidate-all input empties the store in one cycle. Only row identifiers are tracked here. The row data and all DRAM timing are held elsewhere.

Top module: `row_hold_cache`

## Requirements
- R1: After reset no entry is valid, rsp_valid_o and rsp_evict_valid_o are low, and the first lookup of any row misses without an eviction.
- R2: Every lookup accepted on a clock edge produces exactly one response on the following cycle (rsp_valid_o high for one cycle). With no accepted lookup, rsp_valid_o stays low.
- R3: The latency class is 2'b01 for a holding-store hit and 2'b10 for a miss that needs the full DRAM path. It is 2'b00 when no response is presented.
- R4: A missing row is installed, so the next lookup of the same row hits. A row is never held in two slots.
- R5: Empty slots are filled before any eviction. The first ENTRIES distinct misses after an empty state report no eviction.
- R6: In FIFO order (policy_lru_i = 0), a full store evicts the row installed earliest, even if that row was hit after it was installed.
- R7: In LRU order (policy_lru_i = 1), a hit marks the slot as most recently used. A full store evicts the row whose last install or hit is the oldest.
- R8: A miss on a full store raises rsp_evict_valid_o together with the response and puts the displaced row number on rsp_evict_row_o. That row misses afterwards.
- R9: flush_all_i clears every valid bit in one cycle. A lookup in the same cycle as the flush is dropped: it gets no response and installs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_valid_i | input | 1 | Probe request, given after a row-buffer miss |
| lookup_row_i | input | ROW_W | Row number being probed |
| policy_lru_i | input | 1 | 0 selects FIFO order, 1 selects LRU order |
| flush_all_i | input | 1 | Invalidate every entry |
| rsp_valid_o | output | 1 | Response present, one cycle after the probe |
| rsp_hit_o | output | 1 | Row was held |
| rsp_lat_class_o | output | 2 | 01 hold hit, 10 full DRAM miss, 00 idle |
| rsp_evict_valid_o | output | 1 | An entry was displaced by this miss |
| rsp_evict_row_o | output | ROW_W | Row number that was displaced |

## Verification
A corrupted age order does not show up on a hit. It shows up only at the next miss on a full store, where rsp_evict_row_o names the wrong row one cycle after that probe. The directed sequences therefore fill the store, then hit selected rows, then force evictions, so that every ordering decision becomes visible at the evict port. A stale valid bit shows up as a false hit, or as an eviction reported while an empty slot was still free, on the first probe after a flush. A mis-timed response is caught by sampling exactly one cycle after each probe, and also on idle cycles.

// File: rtl/rhc_pkg.sv
package rhc_pkg;

  // Latency class carried with every response
  typedef enum logic [1:0] {
    LAT_NONE = 2'b00,
    LAT_HOLD = 2'b01,
    LAT_DRAM = 2'b10
  } lat_class_e;

  // Replacement order selected by the configuration input
  typedef enum logic {
    POL_FIFO = 1'b0,
    POL_LRU  = 1'b1
  } policy_e;

endpackage

// File: rtl/rhc_tag_array.sv
// Holds the row identifiers and their valid bits; compares all slots in parallel.
module rhc_tag_array #(
  parameter int ENTRIES = 4,
  parameter int ROW_W   = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush_i,
  input  logic                            wr_en_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic [ROW_W-1:0]                wr_row_i,
  input  logic [ROW_W-1:0]                probe_row_i,
  output logic [ENTRIES-1:0]              valid_o,
  output logic [ENTRIES-1:0]              match_o,
  output logic [ENTRIES-1:0][ROW_W-1:0]   rows_o
);

  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0][ROW_W-1:0] rows_q, rows_d;
  logic                          row_we;

  // Next-state logic
  always_comb begin
    valid_d = valid_q;
    rows_d  = rows_q;
    row_we  = 1'b0;
    if (flush_i) begin
      valid_d = '0;
    end else if (wr_en_i) begin
      valid_d[wr_idx_i] = 1'b1;
      rows_d[wr_idx_i]  = wr_row_i;
      row_we            = 1'b1;
    end
  end

  // State registers: valid bits reset, row storage enabled by writes only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_q <= '0;
    end else if (row_we) begin
      rows_q <= rows_d;
    end
  end

  // Parallel comparators
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_q[g] && (rows_q[g] == probe_row_i);
  end

  assign valid_o = valid_q;
  assign rows_o  = rows_q;

  // A row sits in at most one slot, because installs happen only on a miss
  assert_single_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_o));

  // Invalidate-all leaves no valid slot
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_o == '0));

endmodule

// File: rtl/rhc_age_track.sv
// Keeps a permutation of ages: rank 0 is the oldest slot, rank ENTRIES-1 the youngest.
module rhc_age_track #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            touch_en_i,
  input  logic [IDX_W-1:0]                touch_idx_i,
  output logic [IDX_W-1:0]                oldest_idx_o
);

  localparam logic [IDX_W-1:0] YOUNGEST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0][IDX_W-1:0] rank_q, rank_d;
  logic [ENTRIES-1:0]            is_oldest;
  logic [IDX_W-1:0]              touched_rank;

  assign touched_rank = rank_q[touch_idx_i];

  // Next-state: promote the touched slot; slots younger than it age by one
  always_comb begin
    rank_d = rank_q;
    if (touch_en_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx_i) begin
          rank_d[i] = YOUNGEST;
        end else if (rank_q[i] > touched_rank) begin
          rank_d[i] = rank_q[i] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        rank_q[i] <= IDX_W'(i);
      end
    end else if (touch_en_i) begin
      rank_q <= rank_d;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign is_oldest[g] = (rank_q[g] == '0);
  end

  always_comb begin
    oldest_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (is_oldest[i]) oldest_idx_o = IDX_W'(i);
    end
  end

  // The ranks remain a permutation: exactly one slot is the oldest
  assert_one_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(is_oldest));

  // A touched slot becomes the youngest on the next cycle
  assert_touch_youngest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en_i |=> (rank_q[$past(touch_idx_i)] == YOUNGEST));

endmodule

// File: rtl/rhc_victim_sel.sv
// Picks the slot to write: the lowest empty slot, otherwise the oldest by rank.
module rhc_victim_sel #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [IDX_W-1:0]   oldest_idx_i,
  output logic [IDX_W-1:0]   victim_idx_o,
  output logic               full_o
);

  logic [IDX_W-1:0] free_idx;

  assign full_o = &valid_i;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign victim_idx_o = full_o ? oldest_idx_i : free_idx;

endmodule

// File: rtl/row_hold_cache.sv
module row_hold_cache
  import rhc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ROW_W   = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lookup_valid_i,
  input  logic [ROW_W-1:0] lookup_row_i,
  input  logic             policy_lru_i,
  input  logic             flush_all_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [1:0]       rsp_lat_class_o,
  output logic             rsp_evict_valid_o,
  output logic [ROW_W-1:0] rsp_evict_row_o
);

  policy_e                       policy;
  logic [ENTRIES-1:0]            valid;
  logic [ENTRIES-1:0]            match;
  logic [ENTRIES-1:0][ROW_W-1:0] rows;
  logic [IDX_W-1:0]              oldest_idx;
  logic [IDX_W-1:0]              victim_idx;
  logic [IDX_W-1:0]              hit_idx;
  logic                          full;
  logic                          hit_any;
  logic                          accept;
  logic                          install;
  logic                          touch_en;
  logic [IDX_W-1:0]              touch_idx;

  // Response registers
  logic             rsp_valid_q, rsp_valid_d;
  logic             rsp_hit_q, rsp_hit_d;
  lat_class_e       rsp_lat_q, rsp_lat_d;
  logic             ev_valid_q, ev_valid_d;
  logic [ROW_W-1:0] ev_row_q, ev_row_d;

  assign policy = policy_e'(policy_lru_i);

  rhc_tag_array #(.ENTRIES(ENTRIES), .ROW_W(ROW_W)) u_tags (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_all_i),
    .wr_en_i     (install),
    .wr_idx_i    (victim_idx),
    .wr_row_i    (lookup_row_i),
    .probe_row_i (lookup_row_i),
    .valid_o     (valid),
    .match_o     (match),
    .rows_o      (rows)
  );

  rhc_age_track #(.ENTRIES(ENTRIES)) u_age (
    .clk          (clk),
    .rst_n        (rst_n),
    .touch_en_i   (touch_en),
    .touch_idx_i  (touch_idx),
    .oldest_idx_o (oldest_idx)
  );

  rhc_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
    .valid_i      (valid),
    .oldest_idx_i (oldest_idx),
    .victim_idx_o (victim_idx),
    .full_o       (full)
  );

  // Encode the matching slot
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit_any   = |match;
  assign accept    = lookup_valid_i && !flush_all_i;
  assign install   = accept && !hit_any;
  assign touch_en  = install || (accept && hit_any && (policy == POL_LRU));
  assign touch_idx = install ? victim_idx : hit_idx;

  // Response next-state
  always_comb begin
    rsp_valid_d = accept;
    rsp_hit_d   = accept && hit_any;
    rsp_lat_d   = LAT_NONE;
    if (accept) rsp_lat_d = hit_any ? LAT_HOLD : LAT_DRAM;
    ev_valid_d  = install && full;
    ev_row_d    = ev_row_q;
    if (install && full) ev_row_d = rows[victim_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_lat_q   <= LAT_NONE;
      ev_valid_q  <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      rsp_lat_q   <= rsp_lat_d;
      ev_valid_q  <= ev_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_row_q <= '0;
    end else if (ev_valid_d) begin
      ev_row_q <= ev_row_d;
    end
  end

  assign rsp_valid_o       = rsp_valid_q;
  assign rsp_hit_o         = rsp_hit_q;
  assign rsp_lat_class_o   = rsp_lat_q;
  assign rsp_evict_valid_o = ev_valid_q;
  assign rsp_evict_row_o   = ev_row_q;

  // An accepted probe is answered on the next cycle
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid_o);

  // No response without an accepted probe; a probe during a flush is dropped (R9)
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(lookup_valid_i && !flush_all_i) |=> !rsp_valid_o);

  // Evictions only accompany a miss response
  assert_evict_on_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_evict_valid_o |-> (rsp_valid_o && !rsp_hit_o));

  // While a slot is empty, the install target is an empty slot
  assert_fill_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (install && (valid != '1)) |-> !valid[victim_idx]);

endmodule

// File: tb/row_hold_cache_tb.sv
`timescale 1ns/1ps
module row_hold_cache_tb;

  localparam int ENTRIES = 4;
  localparam int ROW_W   = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             lookup_valid;
  logic [ROW_W-1:0] lookup_row;
  logic             policy_lru;
  logic             flush_all;
  logic             rsp_valid;
  logic             rsp_hit;
  logic [1:0]       rsp_lat;
  logic             rsp_ev_valid;
  logic [ROW_W-1:0] rsp_ev_row;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  row_hold_cache #(.ENTRIES(ENTRIES), .ROW_W(ROW_W)) u_dut (
    .clk               (clk),
    .rst_n             (rst_n),
    .lookup_valid_i    (lookup_valid),
    .lookup_row_i      (lookup_row),
    .policy_lru_i      (policy_lru),
    .flush_all_i       (flush_all),
    .rsp_valid_o       (rsp_valid),
    .rsp_hit_o         (rsp_hit),
    .rsp_lat_class_o   (rsp_lat),
    .rsp_evict_valid_o (rsp_ev_valid),
    .rsp_evict_row_o   (rsp_ev_row)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One probe; the response is sampled at the falling edge after the capturing edge
  task automatic do_lookup(input logic [ROW_W-1:0] row, input logic exp_hit,
                           input logic exp_ev, input logic [ROW_W-1:0] exp_ev_row,
                           input string req);
    @(negedge clk);
    lookup_valid = 1'b1;
    lookup_row   = row;
    @(negedge clk);
    lookup_valid = 1'b0;
    chk(req, "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, "rsp_hit", 32'(rsp_hit), 32'(exp_hit));
    chk("R3", "lat_class", 32'(rsp_lat), exp_hit ? 32'd1 : 32'd2);
    chk(req, "evict_valid", 32'(rsp_ev_valid), 32'(exp_ev));
    if (exp_ev) chk("R8", "evict_row", 32'(rsp_ev_row), 32'(exp_ev_row));
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
    chk("R9", "no rsp on flush", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1", "evict_valid after reset", 32'(rsp_ev_valid), 32'd0);
    chk("R3", "idle lat_class", 32'(rsp_lat), 32'd0);
    @(negedge clk);
    chk("R2", "idle no response", 32'(rsp_valid), 32'd0);
    do_lookup(16'h0100, 1'b0, 1'b0, '0, "R1");
    @(negedge clk);
    chk("R2", "single response pulse", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_fifo();
    do_flush();
    policy_lru = 1'b0;
    do_lookup(16'h00A0, 1'b0, 1'b0, '0, "R5");
    do_lookup(16'h00B0, 1'b0, 1'b0, '0, "R5");
    do_lookup(16'h00C0, 1'b0, 1'b0, '0, "R5");
    do_lookup(16'h00D0, 1'b0, 1'b0, '0, "R5");
    do_lookup(16'h00A0, 1'b1, 1'b0, '0, "R4");
    do_lookup(16'h00E0, 1'b0, 1'b1, 16'h00A0, "R6");
    do_lookup(16'h00A0, 1'b0, 1'b1, 16'h00B0, "R8");
    do_lookup(16'h00E0, 1'b1, 1'b0, '0, "R4");
  endtask

  task automatic t_lru();
    do_flush();
    policy_lru = 1'b1;
    do_lookup(16'h0A00, 1'b0, 1'b0, '0, "R5");
    do_lookup(16'h0B00, 1'b0, 1'b0, '0, "R5");
    do_lookup(16'h0C00, 1'b0, 1'b0, '0, "R5");
    do_lookup(16'h0D00, 1'b0, 1'b0, '0, "R5");
    do_lookup(16'h0A00, 1'b1, 1'b0, '0, "R7");
    do_lookup(16'h0E00, 1'b0, 1'b1, 16'h0B00, "R7");
    do_lookup(16'h0C00, 1'b1, 1'b0, '0, "R7");
    do_lookup(16'h0F00, 1'b0, 1'b1, 16'h0D00, "R7");
    do_lookup(16'h0B00, 1'b0, 1'b1, 16'h0A00, "R8");
  endtask

  task automatic t_flush();
    do_flush();
    do_lookup(16'h0E00, 1'b0, 1'b0, '0, "R9");
    // flush and probe in the same cycle: probe is dropped
    @(negedge clk);
    flush_all    = 1'b1;
    lookup_valid = 1'b1;
    lookup_row   = 16'h0777;
    @(negedge clk);
    flush_all    = 1'b0;
    lookup_valid = 1'b0;
    chk("R9", "probe during flush answered", 32'(rsp_valid), 32'd0);
    do_lookup(16'h0E00, 1'b0, 1'b0, '0, "R9");
    do_lookup(16'h0777, 1'b0, 1'b0, '0, "R9");
  endtask

  initial begin
    rst_n        = 1'b0;
    lookup_valid = 1'b0;
    lookup_row   = '0;
    policy_lru   = 1'b0;
    flush_all    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fifo();
    t_lru();
    t_flush();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule